// File: doc/BRIEF.md
# Stack Pointer and Subroutine Sequencer

This block owns a 16-bit stack pointer and turns single stack commands into byte-wide memory cycles. It pushes and pulls one data byte, stacks a 16-bit return address on a call and reloads the program counter from the stack on a return. It also writes the stack pointer out to memory, loads it, steps it by one, and moves it to and from the index value with a one-count adjustment. The stack grows downward. A byte is written at the current pointer and the pointer then drops. A pull raises the pointer first and then reads.

A command is offered on `cmd_valid_i` with an opcode and operands. It is taken only while the block is idle. Memory bytes go out on a request port that holds address, write enable and write data steady until `mem_rdy_i` is seen. After the last byte the block raises `done_o` for one cycle. The updated pointer, program counter, index value and pulled byte are then on the outputs.

Top module: `stack_sub_unit`

## Requirements
- R1: After reset `sp_o`, `pc_o`, `x_o` and `acc_o` are zero and `busy_o`, `done_o` and `mem_req_o` are low.
- R2: Push (opcode 1) writes `cmd_byte_i` at address SP and leaves SP one lower.
- R3: Pull (opcode 2) reads address SP+1, leaves SP one higher and presents the byte read on `acc_o`.
- R4: Call (opcode 3) writes `cmd_link_i[7:0]` at SP and then `cmd_link_i[15:8]` at SP−1. It leaves SP two lower and loads `pc_o` with `cmd_addr_i`.
- R5: Return (opcode 4) reads the high byte at SP+1 and then the low byte at SP+2. It loads `pc_o` with them and leaves SP two higher.
- R6: Store-pointer (opcode 10) writes SP[15:8] at `cmd_addr_i` and SP[7:0] at `cmd_addr_i`+1 (modulo 2^16). SP is not changed.
- R7: Load-pointer (opcode 5) sets SP to `cmd_addr_i`. Increment (opcode 6) and decrement (opcode 7) step SP by one. All pointer arithmetic wraps modulo 2^16.
- R8: Pointer-to-index (opcode 8) sets `x_o` to SP+1. Index-to-pointer (opcode 9) sets SP to `x_i`−1.
- R9: While `mem_req_o` is high and `mem_rdy_i` is low, the request, address, write enable and write data hold. No state advances.
- R10: `busy_o` is high from the cycle after a command is taken until the cycle of `done_o`. `done_o` is a one-cycle pulse. Commands offered while busy, and opcodes 0 and 11 to 15, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_op_i | input | 4 | Command opcode |
| cmd_byte_i | input | 8 | Byte to push |
| cmd_addr_i | input | 16 | Call target, load value or store address |
| cmd_link_i | input | 16 | Return address stacked by a call |
| x_i | input | 16 | Current index value |
| mem_req_o | output | 1 | Memory byte request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_wdata_o | output | 8 | Write byte |
| mem_rdata_i | input | 8 | Read byte |
| mem_rdy_i | input | 1 | Memory completes the current byte |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished |
| sp_o | output | 16 | Stack pointer |
| pc_o | output | 16 | Program counter |
| x_o | output | 16 | Index value from pointer-to-index |
| acc_o | output | 8 | Byte from the last pull |

## Verification
The assertions assume that `mem_rdata_i` is valid in the cycle when `mem_rdy_i` completes a read. They also assume that `mem_rdy_i` is only a handshake and may fall at any time. The stimulus changes every input at the falling edge. It spaces `mem_rdy_i` pulses by a stall count that changes between commands and serves read data from the current address. It deliberately offers commands during busy periods and undefined opcodes to exercise the ignore paths, without breaking those assumptions.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_PUSH  = 4'd1,
    OP_PULL  = 4'd2,
    OP_CALL  = 4'd3,
    OP_RET   = 4'd4,
    OP_LDSP  = 4'd5,
    OP_INCSP = 4'd6,
    OP_DECSP = 4'd7,
    OP_SP2X  = 4'd8,
    OP_X2SP  = 4'd9,
    OP_STSP  = 4'd10
  } stk_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BYTE0 = 2'd1,
    ST_BYTE1 = 2'd2,
    ST_DONE  = 2'd3
  } stk_st_e;

  function automatic logic op_known(logic [OP_W-1:0] c);
    return (c >= 4'd1) && (c <= 4'd10);
  endfunction

  function automatic logic op_mem(stk_op_e o);
    return o inside {OP_PUSH, OP_PULL, OP_CALL, OP_RET, OP_STSP};
  endfunction

  function automatic logic op_two(stk_op_e o);
    return o inside {OP_CALL, OP_RET, OP_STSP};
  endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_valid_i,
  input  logic [OP_W-1:0] cmd_op_i,
  input  logic            mem_rdy_i,
  output stk_st_e         state_o,
  output stk_op_e         op_o,
  output logic            accept_o,
  output logic            fire_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            mem_req_o
);
  stk_st_e state_q, state_d;
  stk_op_e op_q;
  stk_op_e cmd_op;

  assign cmd_op    = stk_op_e'(cmd_op_i);
  assign accept_o  = (state_q == ST_IDLE) && cmd_valid_i && op_known(cmd_op_i);
  assign mem_req_o = (state_q == ST_BYTE0) || (state_q == ST_BYTE1);
  assign fire_o    = mem_req_o && mem_rdy_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign state_o   = state_q;
  assign op_o      = op_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = op_mem(cmd_op) ? ST_BYTE0 : ST_DONE;
      ST_BYTE0: if (fire_o) state_d = op_two(op_q) ? ST_BYTE1 : ST_DONE;
      ST_BYTE1: if (fire_o) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NOP;
    end else begin
      state_q <= state_d;
      if (accept_o) op_q <= cmd_op;
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R10
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o);
endmodule

// File: rtl/stk_regs.sv
module stk_regs
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [DATA_W-1:0] cmd_byte_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] cmd_link_i,
  input  logic [ADDR_W-1:0] x_i,
  input  logic              fire_i,
  input  logic              busy_i,
  input  stk_st_e           state_i,
  input  stk_op_e           op_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [DATA_W-1:0] byte_o,
  output logic [ADDR_W-1:0] opnd_o,
  output logic [ADDR_W-1:0] link_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] sp_q, pc_q, x_q, opnd_q, link_q;
  logic [DATA_W-1:0] acc_q, byte_q, hold_q;
  stk_op_e cmd_op;
  logic    last_beat;

  assign cmd_op    = stk_op_e'(cmd_op_i);
  assign last_beat = (state_i == ST_BYTE1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= SP_RST;
      pc_q   <= '0;
      x_q    <= '0;
      opnd_q <= '0;
      link_q <= '0;
      acc_q  <= '0;
      byte_q <= '0;
      hold_q <= '0;
    end else if (accept_i) begin
      opnd_q <= cmd_addr_i;
      link_q <= cmd_link_i;
      byte_q <= cmd_byte_i;
      unique case (cmd_op)
        OP_LDSP:  sp_q <= cmd_addr_i;
        OP_INCSP: sp_q <= sp_q + ONE;
        OP_DECSP: sp_q <= sp_q - ONE;
        OP_SP2X:  x_q  <= sp_q + ONE;
        OP_X2SP:  sp_q <= x_i - ONE;
        default:  ;
      endcase
    end else if (fire_i) begin
      unique case (op_i)
        OP_PUSH: sp_q <= sp_q - ONE;
        OP_PULL: begin
          sp_q  <= sp_q + ONE;
          acc_q <= rdata_i;
        end
        OP_CALL: begin
          sp_q <= sp_q - ONE;
          if (last_beat) pc_q <= opnd_q;
        end
        OP_RET: begin
          sp_q <= sp_q + ONE;
          if (last_beat) pc_q <= {hold_q, rdata_i};
          else           hold_q <= rdata_i;
        end
        default: ;
      endcase
    end
  end

  assign sp_o   = sp_q;
  assign pc_o   = pc_q;
  assign x_o    = x_q;
  assign acc_o  = acc_q;
  assign byte_o = byte_q;
  assign opnd_o = opnd_q;
  assign link_o = link_q;

  // R10
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !fire_i) |=> $stable(sp_q) && $stable(pc_q) && $stable(x_q));

  // R2
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == OP_PUSH) |=> sp_q == $past(sp_q) - ONE);

  // R8
  sp2x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && cmd_op_i == 4'd8) |=> x_q == $past(sp_q) + ONE);

  // R5
  ret_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && op_i == OP_RET && state_i == ST_BYTE1)
      |=> pc_q == {$past(hold_q), $past(rdata_i)});
endmodule

// File: rtl/stk_bus.sv
module stk_bus
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_st_e           state_i,
  input  stk_op_e           op_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] opnd_i,
  input  logic [ADDR_W-1:0] link_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              req_i,
  input  logic              rdy_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic second;
  assign second = (state_i == ST_BYTE1);

  always_comb begin
    addr_o  = sp_i;
    we_o    = 1'b0;
    wdata_o = '0;
    unique case (op_i)
      OP_PUSH: begin
        we_o    = req_i;
        wdata_o = byte_i;
      end
      OP_PULL, OP_RET: addr_o = sp_i + ONE;
      OP_CALL: begin
        we_o    = req_i;
        wdata_o = second ? link_i[ADDR_W-1:DATA_W] : link_i[DATA_W-1:0];
      end
      OP_STSP: begin
        addr_o  = second ? opnd_i + ONE : opnd_i;
        we_o    = req_i;
        wdata_o = second ? sp_i[DATA_W-1:0] : sp_i[ADDR_W-1:DATA_W];
      end
      default: ;
    endcase
  end

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !rdy_i) |=> req_i && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));
endmodule

// File: rtl/stack_sub_unit.sv
module stack_sub_unit
  import stk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [OP_W-1:0]   cmd_op_i,
  input  logic [DATA_W-1:0] cmd_byte_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [ADDR_W-1:0] cmd_link_i,
  input  logic [ADDR_W-1:0] x_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [DATA_W-1:0] acc_o
);
  stk_st_e           state;
  stk_op_e           op_q;
  logic              accept, fire;
  logic [DATA_W-1:0] byte_q;
  logic [ADDR_W-1:0] opnd_q, link_q;

  stk_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .mem_rdy_i   (mem_rdy_i),
    .state_o     (state),
    .op_o        (op_q),
    .accept_o    (accept),
    .fire_o      (fire),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o)
  );

  stk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .cmd_op_i   (cmd_op_i),
    .cmd_byte_i (cmd_byte_i),
    .cmd_addr_i (cmd_addr_i),
    .cmd_link_i (cmd_link_i),
    .x_i        (x_i),
    .fire_i     (fire),
    .busy_i     (busy_o),
    .state_i    (state),
    .op_i       (op_q),
    .rdata_i    (mem_rdata_i),
    .sp_o       (sp_o),
    .pc_o       (pc_o),
    .x_o        (x_o),
    .acc_o      (acc_o),
    .byte_o     (byte_q),
    .opnd_o     (opnd_q),
    .link_o     (link_q)
  );

  stk_bus #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .op_i    (op_q),
    .sp_i    (sp_o),
    .opnd_i  (opnd_q),
    .link_i  (link_q),
    .byte_i  (byte_q),
    .req_i   (mem_req_o),
    .rdy_i   (mem_rdy_i),
    .addr_o  (mem_addr_o),
    .we_o    (mem_we_o),
    .wdata_o (mem_wdata_o)
  );
endmodule

// File: tb/stack_sub_unit_bench.sv
module stack_sub_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [3:0]  cmd_op_i = '0;
  logic [7:0]  cmd_byte_i = '0;
  logic [15:0] cmd_addr_i = '0;
  logic [15:0] cmd_link_i = '0;
  logic [15:0] x_i = '0;
  logic        mem_req_o, mem_we_o, mem_rdy_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i = '0;
  logic        busy_o, done_o;
  logic [15:0] sp_o, pc_o, x_o;
  logic [7:0]  acc_o;

  stack_sub_unit u_stack_sub_unit (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, stall_mod = 1, rdy_cnt = 0;
  bit finished = 0;
  logic [7:0] mem [int];
  int q_addr[$], q_we[$], q_wd[$];
  // reference state
  logic [15:0] m_sp = '0, m_pc = '0, m_x = '0;
  logic [7:0]  m_acc = '0;

  function automatic logic [7:0] rd(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // memory model and per-clock transaction comparison (R9)
  always @(negedge clk_i) begin
    rdy_cnt++;
    mem_rdy_i = (stall_mod <= 1) || (rdy_cnt % stall_mod == 0);
    mem_rdata_i = rd(int'(mem_addr_o));
    if (mem_req_o && mem_rdy_i) begin
      if (q_addr.size() == 0) chk("R9 unexpected beat", {16'h0, mem_addr_o}, 32'hFFFF_FFFF);
      else begin
        int ea, ew, ed;
        ea = q_addr.pop_front(); ew = q_we.pop_front(); ed = q_wd.pop_front();
        chk("R9 beat addr", {16'h0, mem_addr_o}, ea);
        chk("R9 beat we", {31'h0, mem_we_o}, ew);
        if (ew == 1) begin
          chk("R9 beat wdata", {24'h0, mem_wdata_o}, ed);
          mem[int'(mem_addr_o)] = mem_wdata_o;
        end
      end
    end
  end

  task automatic expect_beat(logic [15:0] a, int we, logic [7:0] d);
    q_addr.push_back(int'(a)); q_we.push_back(we); q_wd.push_back(int'(d));
  endtask

  task automatic run_cmd(string req, logic [3:0] op, logic [7:0] b, logic [15:0] a,
                         logic [15:0] l, bit inject);
    logic [7:0] hi;
    @(negedge clk_i);
    cmd_valid_i = 1; cmd_op_i = op; cmd_byte_i = b; cmd_addr_i = a; cmd_link_i = l;
    case (op)
      4'd1: begin expect_beat(m_sp, 1, b); m_sp = m_sp - 1; end
      4'd2: begin m_sp = m_sp + 1; expect_beat(m_sp, 0, 0); m_acc = rd(int'(m_sp)); end
      4'd3: begin
        expect_beat(m_sp, 1, l[7:0]); expect_beat(m_sp - 16'd1, 1, l[15:8]);
        m_sp = m_sp - 2; m_pc = a;
      end
      4'd4: begin
        expect_beat(m_sp + 16'd1, 0, 0); expect_beat(m_sp + 16'd2, 0, 0);
        hi = rd(int'(m_sp + 16'd1)); m_pc = {hi, rd(int'(m_sp + 16'd2))}; m_sp = m_sp + 2;
      end
      4'd5: m_sp = a;
      4'd6: m_sp = m_sp + 1;
      4'd7: m_sp = m_sp - 1;
      4'd8: m_x = m_sp + 1;
      4'd9: m_sp = x_i - 1;
      4'd10: begin expect_beat(a, 1, m_sp[15:8]); expect_beat(a + 16'd1, 1, m_sp[7:0]); end
      default: ;
    endcase
    @(negedge clk_i);
    chk({req, " R10 busy after accept"}, {31'h0, busy_o}, 1);
    if (inject) begin
      // R10: command offered while busy must be ignored
      cmd_op_i = 4'd5; cmd_addr_i = 16'h1234;
      @(negedge clk_i);
    end
    cmd_valid_i = 0;
    while (!done_o) @(negedge clk_i);
    chk({req, " sp"}, {16'h0, sp_o}, {16'h0, m_sp});
    chk({req, " pc"}, {16'h0, pc_o}, {16'h0, m_pc});
    chk({req, " x"}, {16'h0, x_o}, {16'h0, m_x});
    chk({req, " acc"}, {24'h0, acc_o}, {24'h0, m_acc});
    chk({req, " all beats"}, q_addr.size(), 0);
    @(negedge clk_i);
    chk({req, " R10 done one cycle"}, {30'h0, busy_o, done_o}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 sp", {16'h0, sp_o}, 0);
    chk("R1 pc/x", {pc_o, x_o}, 0);
    chk("R1 acc", {24'h0, acc_o}, 0);
    chk("R1 busy/done/req", {29'h0, busy_o, done_o, mem_req_o}, 0);
    rst_ni = 1;

    run_cmd("R7 load", 4'd5, 0, 16'h1FFF, 0, 0);
    run_cmd("R2 push", 4'd1, 8'h3A, 0, 0, 0);
    chk("R2 mem", {24'h0, rd(16'h1FFF)}, 32'h3A);
    mem[16'h1FFF] = 8'hCE;
    stall_mod = 3;
    run_cmd("R3 pull", 4'd2, 0, 0, 0, 0);
    chk("R3 acc value", {24'h0, acc_o}, 32'hCE);

    run_cmd("R7 reload", 4'd5, 0, 16'h1FFF, 0, 0);
    stall_mod = 4;
    run_cmd("R4 call", 4'd3, 0, 16'h0200, 16'h001A, 0);
    chk("R4 low byte", {24'h0, rd(16'h1FFF)}, 32'h1A);
    chk("R4 high byte", {24'h0, rd(16'h1FFE)}, 32'h00);
    mem[16'h1FFE] = 8'hA5;
    mem[16'h1FFF] = 8'h5C;
    run_cmd("R5 ret", 4'd4, 0, 0, 0, 0);
    chk("R5 pc value", {16'h0, pc_o}, 32'hA55C);

    stall_mod = 2;
    run_cmd("R6 store", 4'd10, 0, 16'h0040, 0, 0);
    chk("R6 hi", {24'h0, rd(16'h0040)}, 32'h1F);
    chk("R6 lo", {24'h0, rd(16'h0041)}, 32'hFF);
    run_cmd("R6 store wrap", 4'd10, 0, 16'hFFFF, 0, 0);
    chk("R6 wrap hi", {24'h0, rd(16'hFFFF)}, 32'h1F);
    chk("R6 wrap lo", {24'h0, rd(16'h0000)}, 32'hFF);

    run_cmd("R8 sp to x", 4'd8, 0, 0, 0, 0);
    x_i = 16'h0100;
    run_cmd("R8 x to sp", 4'd9, 0, 0, 0, 0);
    x_i = 16'h0000;
    run_cmd("R8 x to sp wrap", 4'd9, 0, 0, 0, 0);
    run_cmd("R7 inc wrap", 4'd6, 0, 0, 0, 0);
    run_cmd("R7 dec wrap", 4'd7, 0, 0, 0, 0);
    run_cmd("R7 load zero", 4'd5, 0, 16'h0000, 0, 0);
    stall_mod = 5;
    run_cmd("R2 push wrap", 4'd1, 8'h77, 0, 0, 0);
    chk("R2 wrap mem", {24'h0, rd(16'h0000)}, 32'h77);

    // R10 ignored while busy
    run_cmd("R10 busy ignore", 4'd1, 8'h42, 0, 0, 1);

    // R10 undefined opcodes ignored
    foreach (cmd_op_i[i]) begin end
    for (int op = 11; op <= 16; op++) begin
      @(negedge clk_i);
      cmd_valid_i = 1; cmd_op_i = (op == 16) ? 4'd0 : op[3:0]; cmd_addr_i = 16'hBEEF;
      @(negedge clk_i);
      cmd_valid_i = 0;
      chk("R10 bad opcode busy", {31'h0, busy_o}, 0);
      chk("R10 bad opcode sp", {16'h0, sp_o}, {16'h0, m_sp});
    end

    repeat (3) @(negedge clk_i);
    summary();
  end
endmodule